// File: doc/BRIEF.md
# Host Reset Pulser

This block produces the two ways of resetting the host processor complex. A cold reset pulls the platform power-good signal low through an override output, holds it there for a fixed time and then releases it. The host then reboots with its supplies cycled. A warm reset drives an active-low reset-request line low for a shorter fixed time. Power lines are not touched, so the processor only re-initialises.

Both pulse widths are given in nanoseconds and turned into clock cycles from the clock frequency. A width is never allowed to fall below the electrical minimum of its pulse. Only one pulse runs at a time, and `busy` shows it.

A separate forced-shutdown path sets a sticky override. The override holds deep-sleep power-good low and keeps the resume-well reset asserted until the power sequencer reports that the fully-off state has been reached.

Top module: `host_reset_pulser`

## Requirements
- R1: After reset, `pwrok_force`=0, `rst_req_n`=1, `deep_ok_force`=0, `resume_rst_n`=1 and `busy`=0.
- R2: A `req` with `cold_sel`=1, sampled while idle and with `pwrok_in`=1, raises `pwrok_force` in the following cycle. It stays high for exactly COLD_CYC cycles and then drops. `rst_req_n` stays 1 throughout.
- R3: A cold request sampled while `pwrok_in`=0 is ignored: no pulse starts and `busy` stays 0.
- R4: A `req` with `cold_sel`=0, sampled while idle, drives `rst_req_n` low in the following cycle for exactly WARM_CYC cycles, whatever the level of `pwrok_in`.
- R5: During a warm pulse, `pwrok_force` stays 0 and the shutdown outputs are not changed.
- R6: `busy` is 1 in exactly the cycles in which a pulse is driven. A `req` sampled while busy is dropped: it neither lengthens the running pulse nor starts a second one. A request in the first idle cycle after a pulse is accepted.
- R7: A `shut_req` pulse sets `deep_ok_force`=1 and `resume_rst_n`=0 in the next cycle. Both hold until `off_reached` is sampled high, and clear in the cycle after that.
- R8: When `shut_req` and `off_reached` are sampled in the same cycle, the override is set. The shutdown override and the reset pulser run independently of each other.
- R9: COLD_CYC = max(ceil(CLK_HZ·COLD_NS/1e9), ceil(CLK_HZ·MIN_COLD_NS/1e9)). WARM_CYC is formed the same way from WARM_NS and MIN_WARM_NS. With the defaults (50 MHz, 100 µs, 10 µs, minimums 91 µs and 500 ns) these give 5000 and 500 cycles. Nominal widths of 1 µs and 100 ns are clamped to 4550 and 25 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle reset request strobe |
| cold_sel | input | 1 | 1 selects cold reset, 0 selects warm reset (sampled with `req`) |
| pwrok_in | input | 1 | Present power-good level from the sequencer |
| shut_req | input | 1 | Forced-shutdown strobe |
| off_reached | input | 1 | Sequencer reports the fully-off state |
| pwrok_force | output | 1 | 1 forces platform power-good low (cold pulse) |
| rst_req_n | output | 1 | Active-low reset-request line (warm pulse) |
| deep_ok_force | output | 1 | 1 forces deep-sleep power-good low |
| resume_rst_n | output | 1 | Active-low resume-well reset |
| busy | output | 1 | A pulse is in progress |

## Verification
The scoreboard measures the kind and the length of every pulse. A cold pulse at full width tells a correct counter load apart from an off-by-one. A warm pulse issued with power-good low shows that the power-good gate applies only to cold requests. Requests issued during a pulse, and one issued in the first idle cycle, separate dropping from queueing and from rejecting too early. A clamped second instance tells the minimum-width floor apart from plain conversion. Shutdown strobes are tried alone, held over many cycles, and together with the off report, which shows the set-wins priority.

// File: rtl/host_reset_pulser.sv
module host_reset_pulser #(
  parameter longint CLK_HZ      = 50_000_000,
  parameter longint COLD_NS     = 100_000,
  parameter longint WARM_NS     = 10_000,
  parameter longint MIN_COLD_NS = 91_000,
  parameter longint MIN_WARM_NS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic cold_sel,
  input  logic pwrok_in,
  input  logic shut_req,
  input  logic off_reached,
  output logic pwrok_force,
  output logic rst_req_n,
  output logic deep_ok_force,
  output logic resume_rst_n,
  output logic busy
);
  localparam longint GIGA     = 64'd1_000_000_000;
  localparam longint COLD_NOM = (CLK_HZ * COLD_NS + GIGA - 1) / GIGA;
  localparam longint COLD_MIN = (CLK_HZ * MIN_COLD_NS + GIGA - 1) / GIGA;
  localparam longint WARM_NOM = (CLK_HZ * WARM_NS + GIGA - 1) / GIGA;
  localparam longint WARM_MIN = (CLK_HZ * MIN_WARM_NS + GIGA - 1) / GIGA;
  localparam int COLD_CYC = int'((COLD_NOM > COLD_MIN) ? COLD_NOM : COLD_MIN);
  localparam int WARM_CYC = int'((WARM_NOM > WARM_MIN) ? WARM_NOM : WARM_MIN);
  localparam int LONGEST  = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
  localparam int CW       = $clog2(LONGEST + 1);

  logic [CW-1:0] cnt;
  logic          is_cold;
  logic          shut_hold;
  logic          accept;

  assign busy   = (cnt != '0);
  assign accept = req && !busy && (!cold_sel || pwrok_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      is_cold <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end else if (accept) begin
      cnt     <= cold_sel ? CW'(COLD_CYC) : CW'(WARM_CYC);
      is_cold <= cold_sel;
    end
  end

  assign pwrok_force = busy && is_cold;
  assign rst_req_n   = !(busy && !is_cold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           shut_hold <= 1'b0;
    else if (shut_req)    shut_hold <= 1'b1;
    else if (off_reached) shut_hold <= 1'b0;
  end

  assign deep_ok_force = shut_hold;
  assign resume_rst_n  = !shut_hold;

  // run-length counters used only by the width checks
  logic [CW-1:0] cold_run, warm_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cold_run <= '0;
      warm_run <= '0;
    end else begin
      cold_run <= pwrok_force ? cold_run + 1'b1 : '0;
      warm_run <= !rst_req_n  ? warm_run + 1'b1 : '0;
    end
  end

  p_cold_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req && cold_sel && pwrok_in) |=> (pwrok_force && rst_req_n));

  p_cold_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwrok_force) |-> (cold_run == CW'(COLD_CYC)));

  p_cold_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req && cold_sel && !pwrok_in) |=> !busy);

  p_warm_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req && !cold_sel) |=> (!rst_req_n && !pwrok_force));

  p_warm_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_n) |-> (warm_run == CW'(WARM_CYC)));

  p_warm_no_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_n |-> !pwrok_force);

  p_busy_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (pwrok_force || !rst_req_n));

  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt > 1) |=> (busy && $stable(pwrok_force) && $stable(rst_req_n)));

  p_shut_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req |=> (deep_ok_force && !resume_rst_n));

  p_shut_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_ok_force && !off_reached) |=> deep_ok_force);

  p_shut_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (off_reached && !shut_req) |=> (!deep_ok_force && resume_rst_n));
endmodule

// File: tb/test_host_reset_pulser.sv
module test_host_reset_pulser;
  localparam int COLD_CYC = 5000;
  localparam int WARM_CYC = 500;
  localparam int CLAMP_COLD = 4550;
  localparam int CLAMP_WARM = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, cold_sel = 1'b0, pwrok_in = 1'b1, shut_req = 1'b0, off_reached = 1'b0;
  logic pwrok_force, rst_req_n, deep_ok_force, resume_rst_n, busy;
  logic c_req = 1'b0, c_cold = 1'b0;
  logic c_pwrok_force, c_rst_req_n, c_deep, c_resume, c_busy;

  int total = 0;
  int bad = 0;
  int exp_kind[$];
  int exp_len[$];
  string exp_tag[$];
  int cold_len = 0;
  int warm_len = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  host_reset_pulser i_host_reset_pulser (
    .clk(clk), .rst_n(rst_n), .req(req), .cold_sel(cold_sel), .pwrok_in(pwrok_in),
    .shut_req(shut_req), .off_reached(off_reached), .pwrok_force(pwrok_force),
    .rst_req_n(rst_req_n), .deep_ok_force(deep_ok_force), .resume_rst_n(resume_rst_n),
    .busy(busy));

  host_reset_pulser #(.COLD_NS(1000), .WARM_NS(100)) i_host_reset_pulser_clamp (
    .clk(clk), .rst_n(rst_n), .req(c_req), .cold_sel(c_cold), .pwrok_in(1'b1),
    .shut_req(1'b0), .off_reached(1'b0), .pwrok_force(c_pwrok_force),
    .rst_req_n(c_rst_req_n), .deep_ok_force(c_deep), .resume_rst_n(c_resume),
    .busy(c_busy));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic got_pulse(input int kind, input int len);
    if (exp_kind.size() == 0) begin
      total++; bad++;
      $display("FAIL R3/R6 unexpected pulse: actual kind=%0d len=%0d expected none", kind, len);
    end else begin
      string t;
      t = exp_tag.pop_front();
      check({t, " pulse kind"}, kind, exp_kind.pop_front());
      check({t, " pulse length"}, len, exp_len.pop_front());
    end
  endtask

  // monitor: measures every pulse on the main instance
  always @(negedge clk) begin
    if (rst_n) begin
      if (pwrok_force) cold_len++;
      else if (cold_len > 0) begin got_pulse(1, cold_len); cold_len = 0; end
      if (!rst_req_n) warm_len++;
      else if (warm_len > 0) begin got_pulse(0, warm_len); warm_len = 0; end
    end
  end

  task automatic do_req(input bit cold, input bit expect_pulse, input string tag);
    @(negedge clk);
    req = 1'b1; cold_sel = cold;
    if (expect_pulse) begin
      exp_kind.push_back(cold ? 1 : 0);
      exp_len.push_back(cold ? COLD_CYC : WARM_CYC);
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic clamp_measure(input bit cold, output int len);
    len = 0;
    @(negedge clk);
    c_req = 1'b1; c_cold = cold;
    @(negedge clk);
    c_req = 1'b0;
    while (cold ? c_pwrok_force : !c_rst_req_n) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    check("R1 pwrok_force reset", pwrok_force, 0);
    check("R1 rst_req_n reset", rst_req_n, 1);
    check("R1 deep_ok_force reset", deep_ok_force, 0);
    check("R1 resume_rst_n reset", resume_rst_n, 1);
    check("R1 busy reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 cold pulse
    pwrok_in = 1'b1;
    do_req(1'b1, 1'b1, "R2");
    check("R2 pulse starts next cycle", pwrok_force, 1);
    check("R2 rst_req_n untouched", rst_req_n, 1);
    repeat (10) @(negedge clk);
    check("R6 busy during cold", busy, 1);
    wait_idle();
    check("R6 busy low after cold", busy, 0);

    // R4 and R5 warm pulse
    do_req(1'b0, 1'b1, "R4");
    check("R4 warm starts next cycle", rst_req_n, 0);
    check("R5 pwrok_force during warm", pwrok_force, 0);
    check("R5 deep_ok_force during warm", deep_ok_force, 0);
    check("R5 resume_rst_n during warm", resume_rst_n, 1);
    wait_idle();

    // R3 cold ignored with power-good low
    pwrok_in = 1'b0;
    do_req(1'b1, 1'b0, "R3");
    check("R3 busy stays low", busy, 0);
    check("R3 no cold pulse", pwrok_force, 0);
    repeat (3) @(negedge clk);
    check("R3 still idle", busy, 0);

    // R4 warm with power-good low still runs
    do_req(1'b0, 1'b1, "R4 pwrok low");
    wait_idle();
    pwrok_in = 1'b1;

    // R6 requests while busy are dropped
    do_req(1'b1, 1'b1, "R6 cold with drops");
    repeat (5) @(negedge clk);
    do_req(1'b0, 1'b0, "R6");
    check("R6 warm dropped while busy", rst_req_n, 1);
    do_req(1'b1, 1'b0, "R6");
    wait_idle();
    // first idle cycle: request accepted
    req = 1'b1; cold_sel = 1'b0;
    exp_kind.push_back(0); exp_len.push_back(WARM_CYC); exp_tag.push_back("R6 back-to-back");
    @(negedge clk);
    req = 1'b0;
    check("R6 accepted in first idle cycle", rst_req_n, 0);
    wait_idle();
    repeat (2) @(negedge clk);

    // R7 shutdown override
    shut_req = 1'b1;
    @(negedge clk);
    shut_req = 1'b0;
    check("R7 deep_ok_force set", deep_ok_force, 1);
    check("R7 resume_rst_n asserted", resume_rst_n, 0);
    repeat (20) @(negedge clk);
    check("R7 override holds", deep_ok_force, 1);
    // R8 independence: warm pulse while override held
    do_req(1'b0, 1'b1, "R8 pulse during override");
    check("R8 override kept during pulse", resume_rst_n, 0);
    wait_idle();
    off_reached = 1'b1;
    @(negedge clk);
    off_reached = 1'b0;
    check("R7 cleared after off_reached", deep_ok_force, 0);
    check("R7 resume_rst_n released", resume_rst_n, 1);
    // R8 set wins
    shut_req = 1'b1; off_reached = 1'b1;
    @(negedge clk);
    shut_req = 1'b0; off_reached = 1'b0;
    check("R8 set wins over clear", deep_ok_force, 1);
    off_reached = 1'b1;
    @(negedge clk);
    off_reached = 1'b0;
    check("R8 clear afterwards", deep_ok_force, 0);

    // R9 clamped widths
    clamp_measure(1'b1, len);
    check("R9 cold clamped to minimum", len, CLAMP_COLD);
    clamp_measure(1'b0, len);
    check("R9 warm clamped to minimum", len, CLAMP_WARM);

    repeat (3) @(negedge clk);
    check("R2/R4 expected pulses all seen", exp_kind.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule